// File: doc/BRIEF.md
# Credit-Based Upstream Flow Controller

This block sits at a router output port and keeps count of the free buffer slots in each virtual channel (VC) of the downstream router. Each VC raises a send request. The controller grants one request per cycle, using round-robin order among the VCs that are allowed to send. A VC is allowed to send only when its counter shows at least one free slot. The sender then reports each flit it puts on the link, giving the VC and the flit kind. That report takes one slot from the VC. The downstream router frees slots as it forwards flits, and it returns each freed slot as a credit pulse tagged with a VC number. Each credit gives one slot back to that VC.

A mode input, `cut_through_en`, makes the rule for a new packet stricter. While a VC is between packets, its request must carry the length of the packet waiting at the front. The VC is granted only if its free-slot count covers that whole length. Once the head flit has gone out, the rest of that packet needs only one free slot per flit.

The counters reset to the downstream buffer depth, which defaults to 6. That depth covers the turnaround of 1 cycle of flit travel, 1 cycle of credit travel, 1 cycle of credit handling and a 3-stage router pipeline. A credit that would push a counter above the depth is dropped, and it sets a sticky error flag.

Top module: `credit_fc_ctrl`

## Requirements
- R1: After reset, every VC's credit count equals DEPTH (6 by default), `credit_err` is low, and `grant_vc` is zero while no VC requests.
- R2: A sent flit (`sent_valid` high with VC v) lowers VC v's count by one at the next clock edge.
- R3: A VC whose count is zero is never granted, however long it requests.
- R4: A credit return (`crd_valid` high with VC v) raises VC v's count by one at the next clock edge.
- R5: When a sent flit and a credit return name the same VC in the same cycle, that VC's count stays unchanged and no error is raised.
- R6: A credit return to a VC already at DEPTH leaves the count at DEPTH and sets `credit_err`, which stays high until reset.
- R7: With `cut_through_en` high, a VC that is between packets is granted only if its count is at least its `req_len`. With the mode low, a count of one or more is enough.
- R8: Flit kinds are encoded body=2'b00, head=2'b01, tail=2'b10, single-flit packet=2'b11. A sent head opens a packet on its VC, a sent tail closes it, and a single-flit packet leaves the VC between packets. While a packet is open, cut-through mode needs only a count of one or more, whatever `req_len` says.
- R9: At most one grant is raised per cycle. After reset, VC0 has first priority. After a grant to VC i, the search starts at VC i+1 and wraps to VC0 past the last VC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cut_through_en | input | 1 | Whole-packet credit check for new packets |
| req_vc | input | NUM_VC | Per-VC send request |
| req_len | input | NUM_VC*LEN_W | Per-VC length of the packet at the front, in flits |
| grant_vc | output | NUM_VC | One-hot grant, combinational from the requests |
| sent_valid | input | 1 | A flit went out on the link this cycle |
| sent_vc | input | VC_W | VC of the sent flit |
| sent_kind | input | 2 | Kind of the sent flit |
| crd_valid | input | 1 | A credit arrived from downstream this cycle |
| crd_vc | input | VC_W | VC of the returned credit |
| credit_count | output | NUM_VC*CNT_W | Per-VC free-slot counts |
| credit_err | output | 1 | Sticky flag: a credit returned beyond DEPTH |

## Verification
Sent-flit and credit patterns are each applied to a single VC, so that every count can be checked alone. Applying both to the same VC in one cycle tells the hold rule apart from a lost update. One VC is drained to zero while it keeps requesting, which shows that the credit check gates the grant and not the arbiter. The cut-through check is tried three ways: with the length just above the count, with the length equal to the count, and with the length above the count while a packet is open. Together these separate the rule for a packet's first flit from the rule for the flits that follow. The round-robin order is shown by holding every request high over one full rotation, then by a sparse request set whose next pick has to wrap past the last VC.

// File: rtl/cfc_pkg.sv
// Shared definitions for the credit flow controller.
// Assumes: flit kind is carried as a 2-bit code alongside each sent flit.
package cfc_pkg;
    typedef enum logic [1:0] {
        FLIT_BODY = 2'b00,
        FLIT_HEAD = 2'b01,
        FLIT_TAIL = 2'b10,
        FLIT_SOLO = 2'b11
    } flit_kind_e;
endpackage

// File: rtl/cfc_vc_credit.sv
// One VC's free-slot counter, its packet-open state and its eligibility.
// Assumes: send and ret are single-cycle strobes for this VC; count starts
// at DEPTH (downstream buffer fully empty).
module cfc_vc_credit
    import cfc_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ct_en,
    input  logic             req,
    input  logic [LEN_W-1:0] req_len,
    input  logic             send,
    input  logic [1:0]       send_kind,
    input  logic             ret,
    output logic [CNT_W-1:0] count,
    output logic             pkt_open,
    output logic             eligible,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    // Overflow: a credit with no matching send while already full.
    assign ovf = ret && !send && (count == FULL);

    // Eligible: has credit, and in cut-through mode a new packet must fit whole.
    always_comb begin
        eligible = req && (count != '0);
        if (ct_en && !pkt_open && (int'(count) < int'(req_len)))
            eligible = 1'b0;
    end

    // Counter update: send takes a slot, credit gives one, both cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= FULL;
        end else if (send && !ret) begin
            if (count != '0) count <= count - 1'b1;
        end else if (ret && !send) begin
            if (count != FULL) count <= count + 1'b1;
        end
    end

    // Packet boundary tracking from the kind of each sent flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_open <= 1'b0;
        end else if (send) begin
            if (send_kind == FLIT_HEAD)      pkt_open <= 1'b1;
            else if (send_kind == FLIT_TAIL) pkt_open <= 1'b0;
            else if (send_kind == FLIT_SOLO) pkt_open <= 1'b0;
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    assert_send_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !ret && count != '0) |=> (count == $past(count) - 1'b1));
    assert_ret_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !send && count != FULL) |=> (count == $past(count) + 1'b1));
    assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (send && ret) |=> $stable(count));
endmodule

// File: rtl/cfc_rr_arbiter.sv
// Round-robin pick of one eligible VC per cycle.
// Assumes: the pointer moves to the winner whenever a grant is raised.
module cfc_rr_arbiter #(
    parameter int NUM_VC = 4,
    parameter int PTR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VC-1:0] elig,
    output logic [NUM_VC-1:0] grant
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] win;
    logic             found;

    // Search from the VC after the last winner, wrapping around.
    always_comb begin
        grant = '0;
        win   = ptr_q;
        found = 1'b0;
        for (int off = 1; off <= NUM_VC; off++) begin
            logic [PTR_W-1:0] idx;
            idx = PTR_W'((int'(ptr_q) + off) % NUM_VC);
            if (!found && elig[idx]) begin
                found      = 1'b1;
                win        = idx;
                grant[idx] = 1'b1;
            end
        end
    end

    // Remember the last winner; reset so that VC0 is searched first.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= PTR_W'(NUM_VC - 1);
        else if (found) ptr_q <= win;
    end

    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_elig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~elig) == '0);
endmodule

// File: rtl/credit_fc_ctrl.sv
// Credit flow controller for one router output port: a credit counter per
// downstream VC, round-robin grant, optional whole-packet check.
// Assumes: the sender reports only flits it was granted; credits come back
// one per cycle at most.
module credit_fc_ctrl
    import cfc_pkg::*;
#(
    parameter int NUM_VC  = 4,
    parameter int DEPTH   = 6,
    parameter int MAX_PKT = 8,
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cut_through_en,
    input  logic [NUM_VC-1:0]       req_vc,
    input  logic [NUM_VC*LEN_W-1:0] req_len,
    output logic [NUM_VC-1:0]       grant_vc,
    input  logic                    sent_valid,
    input  logic [VC_W-1:0]         sent_vc,
    input  logic [1:0]              sent_kind,
    input  logic                    crd_valid,
    input  logic [VC_W-1:0]         crd_vc,
    output logic [NUM_VC*CNT_W-1:0] credit_count,
    output logic                    credit_err
);
    logic [NUM_VC-1:0] elig;
    logic [NUM_VC-1:0] ovf;
    logic [NUM_VC-1:0] open_v;

    for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
        logic send_i, ret_i;
        assign send_i = sent_valid && (sent_vc == VC_W'(i));
        assign ret_i  = crd_valid  && (crd_vc  == VC_W'(i));

        cfc_vc_credit #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .ct_en     (cut_through_en),
            .req       (req_vc[i]),
            .req_len   (req_len[i*LEN_W +: LEN_W]),
            .send      (send_i),
            .send_kind (sent_kind),
            .ret       (ret_i),
            .count     (credit_count[i*CNT_W +: CNT_W]),
            .pkt_open  (open_v[i]),
            .eligible  (elig[i]),
            .ovf       (ovf[i])
        );

        assert_no_grant_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vc[i] |-> (credit_count[i*CNT_W +: CNT_W] != '0));
        assert_whole_pkt_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_vc[i] && cut_through_en && !open_v[i]) |->
            (int'(credit_count[i*CNT_W +: CNT_W]) >= int'(req_len[i*LEN_W +: LEN_W])));
        assert_grant_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vc[i] |-> req_vc[i]);
    end

    cfc_rr_arbiter #(.NUM_VC(NUM_VC), .PTR_W(VC_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .grant (grant_vc)
    );

    // Sticky error: any credit beyond the buffer depth.
    always_ff @(posedge clk) begin
        if (!rst_n)     credit_err <= 1'b0;
        else if (|ovf)  credit_err <= 1'b1;
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        credit_err |=> credit_err);
endmodule

// File: tb/tb_credit_fc_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_credit_fc_ctrl;
    localparam int NV = 4, DP = 6, CW = 3, LW = 4;

    logic clk = 1'b0, rst_n = 1'b0, cut_through_en = 1'b0;
    logic [NV-1:0] req_vc = '0;
    logic [NV*LW-1:0] req_len = '0;
    logic [NV-1:0] grant_vc;
    logic sent_valid = 1'b0, crd_valid = 1'b0;
    logic [1:0] sent_vc = '0, crd_vc = '0, sent_kind = 2'b00;
    logic [NV*CW-1:0] credit_count;
    logic credit_err;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    credit_fc_ctrl dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int cnt(input int v);
        return int'(credit_count[v*CW +: CW]);
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_vc = '0; req_len = '0; cut_through_en = 1'b0;
        sent_valid = 1'b0; crd_valid = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic send(input int v, input logic [1:0] k);
        sent_valid = 1'b1; sent_vc = 2'(v); sent_kind = k;
        step();
        sent_valid = 1'b0;
    endtask

    task automatic credit(input int v);
        crd_valid = 1'b1; crd_vc = 2'(v);
        step();
        crd_valid = 1'b0;
    endtask

    task automatic t_reset();   // R1
        do_reset(); #1;
        for (int v = 0; v < NV; v++) check(cnt(v) == DP, "R1 count", cnt(v), DP);
        check(credit_err == 1'b0, "R1 err", int'(credit_err), 0);
        check(grant_vc == '0, "R1 grant", int'(grant_vc), 0);
    endtask

    task automatic t_send_return();   // R2, R4
        do_reset();
        send(1, 2'b00); send(1, 2'b00);
        check(cnt(1) == 4, "R2 decrement", cnt(1), 4);
        check(cnt(0) == DP, "R2 other vc", cnt(0), DP);
        credit(1);
        check(cnt(1) == 5, "R4 increment", cnt(1), 5);
        credit(1);
        check(cnt(1) == 6, "R4 increment", cnt(1), 6);
    endtask

    task automatic t_drain();   // R3
        do_reset();
        for (int i = 0; i < DP; i++) send(2, 2'b00);
        check(cnt(2) == 0, "R3 drained", cnt(2), 0);
        req_vc = 4'b0100; #1;
        check(grant_vc == 4'b0000, "R3 no grant", int'(grant_vc), 0);
        step();
        check(grant_vc == 4'b0000, "R3 still none", int'(grant_vc), 0);
        credit(2); #1;
        check(grant_vc == 4'b0100, "R3 regrant", int'(grant_vc), 4);
    endtask

    task automatic t_same_cycle();   // R5
        do_reset();
        sent_valid = 1'b1; sent_vc = 2'd0; sent_kind = 2'b00;
        crd_valid = 1'b1; crd_vc = 2'd0;
        step();
        sent_valid = 1'b0; crd_valid = 1'b0;
        check(cnt(0) == DP, "R5 full hold", cnt(0), DP);
        check(credit_err == 1'b0, "R5 no err", int'(credit_err), 0);
        send(3, 2'b00);
        sent_valid = 1'b1; sent_vc = 2'd3; crd_valid = 1'b1; crd_vc = 2'd3;
        step();
        sent_valid = 1'b0; crd_valid = 1'b0;
        check(cnt(3) == 5, "R5 mid hold", cnt(3), 5);
    endtask

    task automatic t_overflow();   // R6
        do_reset();
        credit(0);
        check(cnt(0) == DP, "R6 capped", cnt(0), DP);
        check(credit_err == 1'b1, "R6 err set", int'(credit_err), 1);
        send(0, 2'b00);
        check(credit_err == 1'b1, "R6 err sticky", int'(credit_err), 1);
        check(cnt(0) == 5, "R6 count usable", cnt(0), 5);
    endtask

    task automatic t_cut_through();   // R7
        do_reset();
        cut_through_en = 1'b1;
        for (int i = 0; i < 3; i++) send(1, 2'b11);
        req_vc = 4'b0010; req_len[1*LW +: LW] = 4'd4; #1;
        check(grant_vc == 4'b0000, "R7 too short", int'(grant_vc), 0);
        req_len[1*LW +: LW] = 4'd3; #1;
        check(grant_vc == 4'b0010, "R7 exact fit", int'(grant_vc), 2);
        req_len[1*LW +: LW] = 4'd4; cut_through_en = 1'b0; #1;
        check(grant_vc == 4'b0010, "R7 mode off", int'(grant_vc), 2);
    endtask

    task automatic t_open_packet();   // R8
        do_reset();
        cut_through_en = 1'b1;
        send(2, 2'b01);
        for (int i = 0; i < 4; i++) send(2, 2'b00);
        check(cnt(2) == 1, "R8 count", cnt(2), 1);
        req_vc = 4'b0100; req_len[2*LW +: LW] = 4'd8; #1;
        check(grant_vc == 4'b0100, "R8 open packet", int'(grant_vc), 4);
        req_vc = '0;
        send(2, 2'b10);
        credit(2); credit(2);
        req_vc = 4'b0100; req_len[2*LW +: LW] = 4'd3; #1;
        check(grant_vc == 4'b0000, "R8 closed needs fit", int'(grant_vc), 0);
        req_len[2*LW +: LW] = 4'd2; #1;
        check(grant_vc == 4'b0100, "R8 closed fits", int'(grant_vc), 4);
    endtask

    task automatic t_round_robin();   // R9
        logic [NV-1:0] exp [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0001};
        do_reset();
        req_vc = 4'b1111; #1;
        for (int c = 0; c < 5; c++) begin
            check(grant_vc == exp[c], "R9 rotation", int'(grant_vc), int'(exp[c]));
            step();
        end
        req_vc = 4'b1010; #1;
        check(grant_vc == 4'b0010, "R9 sparse", int'(grant_vc), 2);
        step();
        check(grant_vc == 4'b1000, "R9 sparse next", int'(grant_vc), 8);
        step();
        check(grant_vc == 4'b0010, "R9 wrap", int'(grant_vc), 2);
    endtask

    initial begin
        t_reset();
        t_send_return();
        t_drain();
        t_same_cycle();
        t_overflow();
        t_cut_through();
        t_open_packet();
        t_round_robin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule